// File: doc/BRIEF.md
# Chip-Select Access Guard

The guard sits between an internal bus master and the controller that runs external local-bus cycles. Each request names a chip-select region and a direction. Before any external cycle starts, the guard decides whether to pass the request on. Each region has three configuration bits: region enable, read-only and write-only. A small control register holds a global master enable and an interrupt enable. Region 0 is the boot region. The master enable does not gate it, so it is switched off only through its own region enable.

A request that passes is forwarded in the same cycle, with its region and direction unchanged. A request that is refused is answered with an error acknowledge on the next cycle, so the master never waits. Some refusals are direction violations: a write to a read-only region, or a read from a write-only region. These set sticky status flags, which software clears by writing ones. External transfer-completion and FIFO-error events set further sticky flags. A registered interrupt output reports any set flag when the interrupt enable is on.

Top module: `csAccessGuard`

## Requirements
- R1: A write to an enabled, permitted region whose read-only bit is 1 is not forwarded. On the next clock edge it sets status bit 1, the read-only violation flag.
- R2: A read from an enabled, permitted region whose write-only bit is 1 is not forwarded. On the next clock edge it sets status bit 0, the write-only violation flag.
- R3: A request that is allowed drives fwdValid high in the same cycle, with fwdWrite and fwdCs equal to the request's direction and region.
- R4: Every refused request drives errAck high for exactly one cycle, following the clock edge that samples the request. errAck is low after any edge that samples no refused request.
- R5: While control bit 0 (master enable) is 0, requests to regions 1 and above are refused and set no violation flag. The control and status registers can still be written and read back.
- R6: Requests to region 0 are not affected by the master enable. Region 0 is refused only when its own region enable is 0, or when a direction violation occurs.
- R7: A request to a region whose region enable is 0 is refused and sets no violation flag.
- R8: Status flags are sticky. A flag is cleared by a status write with a 1 in that bit position. If hardware sets a flag in the same cycle that software clears it, the flag stays set.
- R9: A pulse on xferDone sets status bit 2. A pulse on fifoErr sets status bit 3.
- R10: On each clock edge, irq takes the value of control bit 1 (interrupt enable) ANDed with the OR of all status flags, using the register values from before that edge.
- R11: After reset, the control register, the status register, irq and errAck are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request from the internal master |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqCs | input | CS_W | Target chip-select region |
| csEnable | input | NUM_CS | Region enable, one bit per region |
| csReadOnly | input | NUM_CS | Region read-only bit, one bit per region |
| csWriteOnly | input | NUM_CS | Region write-only bit, one bit per region |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 2 | Control write data: bit 0 master enable, bit 1 interrupt enable |
| statusWe | input | 1 | Status write strobe (write one to clear) |
| statusWdata | input | 4 | Status write data; a 1 clears that flag |
| xferDone | input | 1 | Transfer finished, normal or aborted |
| fifoErr | input | 1 | FIFO underrun or overrun |
| fwdValid | output | 1 | Forwarded request to the external controller |
| fwdWrite | output | 1 | Direction of the forwarded request |
| fwdCs | output | CS_W | Region of the forwarded request |
| errAck | output | 1 | Error acknowledge for a refused request |
| ctrlQ | output | 2 | Control register readback |
| statusQ | output | 4 | Status register readback |
| irq | output | 1 | Registered interrupt request |

## Verification
A wrong permission decision shows up at once on fwdValid, in the same cycle as the request. A missing or stray error response shows up on errAck one edge later. A corrupted status flag shows up on statusQ one edge after the triggering request or event. Its effect on irq follows one edge after that. The bench sweeps every combination of region, direction, region enable, read-only, write-only and master enable, so each permission outcome is observed. Directed sequences then cover set-over-clear priority and the timing of irq.

// File: rtl/csGuardPkg.sv
package csGuardPkg;
  localparam int STAT_W  = 4;
  localparam int ST_WO   = 0;
  localparam int ST_RO   = 1;
  localparam int ST_DONE = 2;
  localparam int ST_FIFO = 3;
  localparam int CTRL_W  = 2;
  localparam int CT_ME   = 0;
  localparam int CT_IE   = 1;

  typedef struct packed {
    logic fwd;
    logic block;
    logic setRo;
    logic setWo;
  } guardStrobes_t;
endpackage

// File: rtl/csCheckCtrl.sv
module csCheckCtrl
  import csGuardPkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [NUM_CS-1:0] csEnable,
  input  logic [NUM_CS-1:0] csReadOnly,
  input  logic [NUM_CS-1:0] csWriteOnly,
  input  logic              masterEn,
  output guardStrobes_t     strb
);
  logic regionOn, globalOk, roHit, woHit, permitted;

  always_comb begin
    regionOn  = csEnable[reqCs];
    // boot region ignores the global enable
    globalOk  = (reqCs == '0) || masterEn;
    permitted = regionOn && globalOk;
    roHit     = reqWrite && csReadOnly[reqCs];
    woHit     = !reqWrite && csWriteOnly[reqCs];
    strb.fwd   = reqValid && permitted && !roHit && !woHit;
    strb.block = reqValid && !strb.fwd;
    strb.setRo = reqValid && permitted && roHit;
    strb.setWo = reqValid && permitted && woHit;
  end
endmodule

// File: rtl/csStatusPath.sv
module csStatusPath
  import csGuardPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobes_t     strb,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              statusWe,
  input  logic [STAT_W-1:0] statusWdata,
  input  logic              xferDone,
  input  logic              fifoErr,
  output logic              masterEn,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic [STAT_W-1:0] statusQ,
  output logic              errAck,
  output logic              irq
);
  logic [STAT_W-1:0] setVec, clrVec, statusNext;

  always_comb begin
    setVec          = '0;
    setVec[ST_WO]   = strb.setWo;
    setVec[ST_RO]   = strb.setRo;
    setVec[ST_DONE] = xferDone;
    setVec[ST_FIFO] = fifoErr;
    clrVec          = statusWe ? statusWdata : '0;
    statusNext      = (statusQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      statusQ <= '0;
      errAck  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (ctrlWe) ctrlQ <= ctrlWdata;
      statusQ <= statusNext;
      errAck  <= strb.block;
      irq     <= ctrlQ[CT_IE] && (|statusQ);
    end
  end

  assign masterEn = ctrlQ[CT_ME];
endmodule

// File: rtl/csAccessGuard.sv
module csAccessGuard
  import csGuardPkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [NUM_CS-1:0] csEnable,
  input  logic [NUM_CS-1:0] csReadOnly,
  input  logic [NUM_CS-1:0] csWriteOnly,
  input  logic              ctrlWe,
  input  logic [1:0]        ctrlWdata,
  input  logic              statusWe,
  input  logic [3:0]        statusWdata,
  input  logic              xferDone,
  input  logic              fifoErr,
  output logic              fwdValid,
  output logic              fwdWrite,
  output logic [CS_W-1:0]   fwdCs,
  output logic              errAck,
  output logic [1:0]        ctrlQ,
  output logic [3:0]        statusQ,
  output logic              irq
);
  guardStrobes_t strb;
  logic masterEn;

  csCheckCtrl #(.NUM_CS(NUM_CS)) uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqCs(reqCs),
    .csEnable(csEnable), .csReadOnly(csReadOnly), .csWriteOnly(csWriteOnly),
    .masterEn(masterEn), .strb(strb)
  );

  csStatusPath uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .statusWe(statusWe), .statusWdata(statusWdata),
    .xferDone(xferDone), .fifoErr(fifoErr),
    .masterEn(masterEn), .ctrlQ(ctrlQ), .statusQ(statusQ),
    .errAck(errAck), .irq(irq)
  );

  assign fwdValid = strb.fwd;
  assign fwdWrite = reqWrite;
  assign fwdCs    = reqCs;
endmodule

// File: rtl/csGuardChecker.sv
module csGuardChecker #(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [CS_W-1:0]   reqCs,
  input logic [NUM_CS-1:0] csEnable,
  input logic [NUM_CS-1:0] csReadOnly,
  input logic [NUM_CS-1:0] csWriteOnly,
  input logic              statusWe,
  input logic [3:0]        statusWdata,
  input logic              fwdValid,
  input logic              fwdWrite,
  input logic [CS_W-1:0]   fwdCs,
  input logic              errAck,
  input logic [1:0]        ctrlQ,
  input logic [3:0]        statusQ,
  input logic              irq
);
  assert_ro_no_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdWrite) |-> !csReadOnly[fwdCs]);

  assert_wo_no_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdWrite) |-> !csWriteOnly[fwdCs]);

  assert_fwd_matches_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (reqValid && fwdCs == reqCs && fwdWrite == reqWrite));

  assert_err_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !fwdValid) |=> errAck);

  assert_no_spurious_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !fwdValid) |=> !errAck);

  assert_master_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && fwdCs != '0) |-> ctrlQ[0]);

  assert_region_enable_R7: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> csEnable[fwdCs]);

  for (genvar k = 0; k < 4; k++) begin : gSticky
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[k] && !(statusWe && statusWdata[k])) |=> statusQ[k]);
  end

  assert_irq_timing_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past(ctrlQ[1] && (|statusQ))));
endmodule

bind csAccessGuard csGuardChecker #(.NUM_CS(NUM_CS)) uChk (.*);

// File: tb/sim_csAccessGuard.sv
module sim_csAccessGuard;
  localparam int NUM_CS = 4;
  localparam int CS_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0;
  logic [CS_W-1:0] reqCs = '0;
  logic [NUM_CS-1:0] csEnable = '0, csReadOnly = '0, csWriteOnly = '0;
  logic ctrlWe = 0, statusWe = 0, xferDone = 0, fifoErr = 0;
  logic [1:0] ctrlWdata = '0;
  logic [3:0] statusWdata = '0;
  logic fwdValid, fwdWrite, errAck, irq;
  logic [CS_W-1:0] fwdCs;
  logic [1:0] ctrlQ;
  logic [3:0] statusQ;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csAccessGuard #(.NUM_CS(NUM_CS)) u0 (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 ctrl", ctrlQ, 0);
    check("R11 status", statusQ, 0);
    check("R11 irq", irq, 0);
    check("R11 errAck", errAck, 0);
    rstN = 1;

    // exhaustive permission sweep
    for (int combo = 0; combo < 128; combo++) begin
      automatic int cs = combo & 3;
      automatic bit w  = combo[2];
      automatic bit en = combo[3];
      automatic bit ro = combo[4];
      automatic bit wo = combo[5];
      automatic bit me = combo[6];
      automatic bit gOk = (cs == 0) || me;
      automatic bit permitted = en && gOk;
      automatic bit roV = permitted && w && ro;
      automatic bit woV = permitted && !w && wo;
      automatic bit allow = permitted && !(w && ro) && !(!w && wo);
      @(negedge clk);
      check("R4 errAck idle", errAck, 0);
      csEnable = '0; csReadOnly = '0; csWriteOnly = '0;
      csEnable[cs] = en; csReadOnly[cs] = ro; csWriteOnly[cs] = wo;
      ctrlWe = 1; ctrlWdata = {1'b0, me};
      statusWe = 1; statusWdata = 4'hF;
      @(negedge clk);
      ctrlWe = 0; statusWe = 0;
      check("R5 ctrl readback", ctrlQ, int'(me));
      reqValid = 1; reqWrite = w; reqCs = CS_W'(cs);
      #1;
      check(cs == 0 ? "R6 fwdValid" : (!en ? "R7 fwdValid" : "R3 fwdValid"), fwdValid, int'(allow));
      if (allow) begin
        check("R3 fwdCs", fwdCs, cs);
        check("R3 fwdWrite", fwdWrite, int'(w));
      end
      @(negedge clk);
      reqValid = 0;
      check("R4 errAck", errAck, int'(!allow));
      check(roV ? "R1 status" : (woV ? "R2 status" : "R5 R7 no flag status"),
            statusQ, (int'(roV) << 1) | int'(woV));
    end

    // R8 set beats clear
    @(negedge clk);
    csEnable = 4'b0001; csReadOnly = 4'b0001; csWriteOnly = '0;
    ctrlWe = 1; ctrlWdata = 2'b00;
    statusWe = 1; statusWdata = 4'hF;
    @(negedge clk);
    ctrlWe = 0; statusWe = 0;
    reqValid = 1; reqWrite = 1; reqCs = 0;
    @(negedge clk);
    check("R8 flag set", statusQ, 2);
    statusWe = 1; statusWdata = 4'b0010;
    @(negedge clk);
    reqValid = 0; statusWe = 0;
    check("R8 set wins", statusQ, 2);
    statusWe = 1; statusWdata = 4'b0001;
    @(negedge clk);
    statusWe = 0;
    check("R8 other bit clear keeps flag", statusQ, 2);
    statusWe = 1; statusWdata = 4'b0010;
    @(negedge clk);
    statusWe = 0;
    check("R8 w1c", statusQ, 0);

    // R9 events, R10 irq timing
    ctrlWe = 1; ctrlWdata = 2'b10;
    @(negedge clk);
    ctrlWe = 0;
    check("R10 irq quiet", irq, 0);
    xferDone = 1;
    @(negedge clk);
    xferDone = 0;
    check("R9 done flag", statusQ, 4);
    check("R10 irq lag", irq, 0);
    @(negedge clk);
    check("R10 irq set", irq, 1);
    statusWe = 1; statusWdata = 4'b0100;
    @(negedge clk);
    statusWe = 0;
    check("R8 done cleared", statusQ, 0);
    check("R10 irq holds one edge", irq, 1);
    @(negedge clk);
    check("R10 irq cleared", irq, 0);
    ctrlWe = 1; ctrlWdata = 2'b00;
    fifoErr = 1;
    @(negedge clk);
    ctrlWe = 0; fifoErr = 0;
    check("R9 fifo flag", statusQ, 8);
    @(negedge clk);
    check("R10 irq masked", irq, 0);
    finish();
  end
endmodule